// File: doc/BRIEF.md
# Event Flag and Interrupt Enable Register

This block is the event and interrupt register of a serial bus engine. One 32-bit word holds eight sticky event flags in its low byte and eight matching enables in the byte above. Single-cycle pulses from the engine set the flags. The block drives one level interrupt line, which is high while any flag is set together with its enable.

Software reaches the word through three neighbouring addresses on a simple register port. The first replaces the word with the write data. The second sets the written ones. The third clears the written ones. With the set and clear addresses, one flag or one enable can be changed without reading the word first. A flag stays set until software clears it, and a hardware event arriving in the same cycle as a clear is never lost.

Top module: `evt_irq_reg`

## Requirements
- R1: After reset every flag and enable reads 0 and `irq` is 0.
- R2: An `evt_pulse[n]` high at a clock edge sets flag bit n at that edge, and the flag stays set while no software write clears it.
- R3: A write to the base address 0x40 replaces flags (bits 7:0) and enables (bits 15:8) with `wdata[15:0]`. Bits 31:16 are ignored on write and read as 0.
- R4: A write to base+0x4 (0x44) sets every flag and enable bit whose `wdata` bit is 1 and leaves the others unchanged.
- R5: A write to base+0x8 (0x48) clears every flag and enable bit whose `wdata` bit is 1 and leaves the others unchanged.
- R6: When an event pulse and a software write that would leave that flag at 0 (clear or plain write) fall in the same cycle, the flag ends up set.
- R7: `rdata` shows the current word whenever `addr` is any of 0x40, 0x44 or 0x48. At any other address it is 0, and writes there change nothing.
- R8: `irq` is registered. At each clock edge it takes the OR over n of (flag n AND enable n) as held before that edge, so it follows a register change one cycle later.
- R9: The enable for flag n is bit n+8. An enable gates only its own flag. Flag order from bit 0 up: slave event, slave stop, master arbitration loss, early termination, oversize transfer, no slave acknowledge, data engine complete, bus free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 8 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data; combinational from `addr` |
| evt_pulse | input | 8 | Hardware event pulses, one per flag |
| irq | output | 1 | Registered level interrupt |

## Verification
The stimulus uses overlapping bit patterns for the set, clear and plain-write addresses. This tells OR and AND-NOT behaviour apart from plain replacement. A flag whose enable is clear is kept next to a flag whose enable is set, which shows that each enable gates only its own flag. An event pulse is driven in the same cycle as a clear or a plain write of zero, which shows that the set wins. The word is read back at each alias address and at an unused address, and a write to the unused address is tried. Reads taken right after a write show the one-cycle lag of `irq` behind the register.

// File: rtl/evt_irq_reg.sv
module evt_irq_reg #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_EVT = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40,
  parameter int unsigned SET_OFS = 4,
  parameter int unsigned CLR_OFS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_EVT-1:0]  evt_pulse,
  output logic              irq
);
  localparam int unsigned REG_W = 2 * N_EVT;
  localparam logic [ADDR_W-1:0] SET_ADDR = BASE_ADDR + ADDR_W'(SET_OFS);
  localparam logic [ADDR_W-1:0] CLR_ADDR = BASE_ADDR + ADDR_W'(CLR_OFS);

  logic [N_EVT-1:0] stat_q, en_q;
  logic [REG_W-1:0] cur, wv, nxt;
  logic             hit_rw, hit_set, hit_clr;

  assign hit_rw  = addr == BASE_ADDR;
  assign hit_set = addr == SET_ADDR;
  assign hit_clr = addr == CLR_ADDR;
  assign cur     = {en_q, stat_q};
  assign wv      = wdata[REG_W-1:0];

  always_comb begin
    nxt = cur;
    if (wr_en) begin
      if (hit_rw)       nxt = wv;
      else if (hit_set) nxt = cur | wv;
      else if (hit_clr) nxt = cur & ~wv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= nxt[N_EVT-1:0] | evt_pulse;
      en_q   <= nxt[REG_W-1:N_EVT];
      irq    <= |(stat_q & en_q);
    end
  end

  assign rdata = (hit_rw || hit_set || hit_clr) ? {{(DATA_W-REG_W){1'b0}}, cur} : '0;
endmodule

// File: rtl/evt_irq_reg_chk.sv
module evt_irq_reg_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_EVT = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40,
  parameter int unsigned SET_OFS = 4,
  parameter int unsigned CLR_OFS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [2*N_EVT-1:0] wv,
  input logic [N_EVT-1:0]  evt_pulse,
  input logic [N_EVT-1:0]  stat_q,
  input logic [N_EVT-1:0]  en_q,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] SET_ADDR = BASE_ADDR + ADDR_W'(SET_OFS);
  localparam logic [ADDR_W-1:0] CLR_ADDR = BASE_ADDR + ADDR_W'(CLR_OFS);

  a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse)));

  a_r4_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SET_ADDR) |=> (({en_q, stat_q} & $past(wv)) == $past(wv)));

  a_r5_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CLR_ADDR && evt_pulse == '0) |=> (({en_q, stat_q} & $past(wv)) == '0));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && evt_pulse == '0) |=> ({en_q, stat_q} == $past({en_q, stat_q})));

  a_r8_irq_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(stat_q & en_q))));
endmodule

bind evt_irq_reg evt_irq_reg_chk #(
  .ADDR_W(ADDR_W), .N_EVT(N_EVT), .BASE_ADDR(BASE_ADDR),
  .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wv(wv),
  .evt_pulse(evt_pulse), .stat_q(stat_q), .en_q(en_q), .irq(irq)
);

// File: tb/evt_irq_reg_bench.sv
`timescale 1ns/1ps
module evt_irq_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [7:0]  evt = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        mon_go = 1'b0;
  logic        done = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;

  typedef struct {logic [31:0] d; logic q; string tag;} item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  evt_irq_reg u_evt_irq_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt_pulse(evt), .irq(irq)
  );

  task automatic drive(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [7:0] e);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; evt = e; mon_go = 1'b0;
  endtask

  task automatic expect_now(input logic [7:0] a, input logic [31:0] d, input logic q, input string tag);
    @(negedge clk);
    wr_en = 1'b0; evt = '0; addr = a; wdata = '0;
    sb.push_back('{d, q, tag});
    mon_go = 1'b1;
  endtask

  task automatic expect_settled(input logic [7:0] a, input logic [31:0] d, input logic q, input string tag);
    drive(1'b0, a, '0, '0);
    expect_now(a, d, q, tag);
  endtask

  always begin
    @(negedge clk);
    #1;
    if (mon_go && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (rdata !== it.d || irq !== it.q) begin
        n_fail++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b", it.tag, rdata, irq, it.d, it.q);
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    expect_now(8'h40, 32'h0, 1'b0, "R1 reset clear");
    drive(1'b0, 8'h40, '0, 8'h05);
    expect_settled(8'h40, 32'h0000_0005, 1'b0, "R2 event sets flags");
    expect_settled(8'h40, 32'h0000_0005, 1'b0, "R2 flags sticky");
    drive(1'b1, 8'h44, 32'h0000_0100, '0);
    expect_settled(8'h40, 32'h0000_0105, 1'b1, "R4 set alias enable, R8 irq");
    drive(1'b1, 8'h48, 32'h0000_0001, '0);
    expect_settled(8'h40, 32'h0000_0104, 1'b0, "R5 clear flag, R9 bit0 enable ignores bit2");
    drive(1'b1, 8'h44, 32'h0000_0400, '0);
    expect_settled(8'h40, 32'h0000_0504, 1'b1, "R9 enable bit10 gates flag2");
    drive(1'b1, 8'h40, 32'hFFFF_3A81, '0);
    expect_settled(8'h40, 32'h0000_3A81, 1'b0, "R3 plain write, upper bits dropped");
    expect_now(8'h44, 32'h0000_3A81, 1'b0, "R7 read at set alias");
    expect_now(8'h48, 32'h0000_3A81, 1'b0, "R7 read at clear alias");
    expect_now(8'h4C, 32'h0, 1'b0, "R7 unused address reads 0");
    drive(1'b1, 8'h50, 32'h0000_FFFF, '0);
    expect_settled(8'h40, 32'h0000_3A81, 1'b0, "R7 write to unused address ignored");
    drive(1'b1, 8'h48, 32'h0000_0081, 8'h80);
    expect_settled(8'h40, 32'h0000_3A80, 1'b0, "R6 event beats clear alias");
    drive(1'b1, 8'h40, 32'h0, 8'h02);
    expect_settled(8'h40, 32'h0000_0002, 1'b0, "R6 event beats plain write");
    drive(1'b1, 8'h44, 32'h0000_0200, '0);
    expect_now(8'h40, 32'h0000_0202, 1'b0, "R8 irq lags one cycle");
    expect_now(8'h40, 32'h0000_0202, 1'b1, "R8 irq rises next cycle");
    drive(1'b1, 8'h48, 32'h0000_0002, '0);
    expect_settled(8'h40, 32'h0000_0200, 1'b0, "R5 clear flag drops irq");
    drive(1'b1, 8'h48, 32'h0000_0200, 8'h80);
    expect_settled(8'h40, 32'h0000_0080, 1'b0, "R5 clear enable, R2 bus-free flag");
    drive(1'b0, 8'h00, '0, '0);
    drive(1'b0, 8'h00, '0, '0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule